// File: doc/BRIEF.md
# Iterative Bitsliced Block Encryptor

This block encrypts one 128-bit block, carried as four 32-bit words, in 32 rounds at one round per clock. Each round XORs a 128-bit round subkey into the state. It then passes every bit column through one of eight 4-bit substitution boxes. A column is the four bits at the same position in the four words. Last, a rotate/shift/XOR network mixes the four words together. The final round drops the mixing network and XORs in one more subkey, so one block uses 33 subkeys.

Subkeys come from outside. The block drives a subkey index, and the surrounding logic must answer in the same cycle with the four words of that subkey. Typical sources are a small register file or a key-schedule memory read without a register. A start strobe loads the plaintext. After the run, a one-cycle done pulse marks the cycle in which the ciphertext becomes valid. The ciphertext then stays unchanged until the next run completes.

Top module: `iter_block_cipher`

## Requirements
- R1: In every round, each state word is first XORed with the subkey word of the same number (`sk0` with word 0, and so on through `sk3` with word 3).
- R2: Round r uses box number r mod 8. Box v maps inputs 0..15 to the hex digits listed here in input order. Box 0: 38F1A65BED42709C. Box 1: FC27905A1BE86D34. Box 2: 86793CAFD1E40B52. Box 3: 0FB8C963D124A75E. Box 4: 1F83C0B6254A9E7D. Box 5: F52B4A9C03E8D671. Box 6: 72C5846BE91FD3A0. Box 7: 1DF0E82B74CA9356.
- R3: For each bit position c, the box input is the nibble {w3[c], w2[c], w1[c], w0[c]}, so word 0 supplies the least significant bit. Output bit k of the box goes back to bit c of word k.
- R4: After the boxes in rounds 0..30, the words are mixed in this order. First, w0 rotates left 13 and w2 rotates left 3. Next, w1 = w1^w0^w2 and w3 = w3^w2^(w0 shifted left 3, zero fill). Then w1 rotates left 1 and w3 rotates left 7. Then w0 = w0^w1^w3 and w2 = w2^w3^(w1 shifted left 7, zero fill). Finally, w0 rotates left 5 and w2 rotates left 22.
- R5: Round 31 skips the mixing. Its box output is XORed with subkey 32 to form the ciphertext.
- R6: `key_idx` is 0 in the cycle after start is accepted and rises by one each cycle up to 32. The subkey inputs are sampled in the cycle where `key_idx` names them.
- R7: `done` goes high for exactly one cycle, 33 clock edges after the edge that samples `start`. In that same cycle `ct0..ct3` first show the new ciphertext.
- R8: The ciphertext outputs do not change except in the cycle `done` is high. After a run they hold through idle time and through the whole next run.
- R9: A `start` raised while a block is in progress has no effect. The running block finishes on its original schedule with its original result, and no second `done` follows.
- R10: A synchronous active-high `rst` returns the block to idle, sets `key_idx` to 0, and clears `done` and the ciphertext outputs to 0, including in the middle of a run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin encrypting `pt0..pt3` (taken only when idle) |
| pt0 | input | 32 | Plaintext word 0 |
| pt1 | input | 32 | Plaintext word 1 |
| pt2 | input | 32 | Plaintext word 2 |
| pt3 | input | 32 | Plaintext word 3 |
| key_idx | output | 6 | Number of the subkey wanted this cycle |
| sk0 | input | 32 | Subkey word 0 for `key_idx` |
| sk1 | input | 32 | Subkey word 1 for `key_idx` |
| sk2 | input | 32 | Subkey word 2 for `key_idx` |
| sk3 | input | 32 | Subkey word 3 for `key_idx` |
| ct0 | output | 32 | Ciphertext word 0 |
| ct1 | output | 32 | Ciphertext word 1 |
| ct2 | output | 32 | Ciphertext word 2 |
| ct3 | output | 32 | Ciphertext word 3 |
| done | output | 1 | One-cycle pulse: ciphertext just updated |

## Verification
Results arrive on a fixed timeline counted from the edge that samples `start`. `key_idx` equals k after edge k, for k from 0 to 32. `done` and the new ciphertext appear after edge 33, and `done` is low again after edge 34. The bench drives on falling edges and also samples on falling edges. It counts falling edges from the launch, compares `key_idx` against that count, and checks the done latency, the ciphertext, and the drop of `done` one edge later. Runs cover a sweep of all sixteen uniform column values with zero keys, walking-bit and mixed plaintexts with nonzero keys, a start raised mid-run, idle hold, and a reset raised mid-run.

// File: rtl/iter_block_cipher_pkg.sv
package iter_block_cipher_pkg;

  localparam int NUM_BOXES = 8;
  localparam int BOX_SEL_W = $clog2(NUM_BOXES);
  localparam int LANES     = 4;

  // Each entry packs one 4-bit box: output for input v sits at bits [4v+3:4v].
  localparam logic [63:0] BOX_TBL [NUM_BOXES] = '{
    64'hC90724DEB56A1F83,
    64'h43D68EB1A50972CF,
    64'h25B04E1DFAC39768,
    64'hE57A421D369C8BF0,
    64'hD7E9A4526B0C38F1,
    64'h176D8E30C9A4B25F,
    64'h0A3DF19EB6485C27,
    64'h6539AC47B28E0FD1
  };

  function automatic logic [3:0] box_lookup(input logic [BOX_SEL_W-1:0] sel,
                                            input logic [3:0] v);
    logic [63:0] row;
    row = BOX_TBL[sel];
    return row[{v, 2'b00} +: 4];
  endfunction

endpackage

// File: rtl/iter_block_cipher_sbox.sv
module iter_block_cipher_sbox
  import iter_block_cipher_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [BOX_SEL_W-1:0]          box_sel,
  input  logic [LANES-1:0][WORD_W-1:0]  din,
  output logic [LANES-1:0][WORD_W-1:0]  dout
);

  // One box instance per bit column; word 0 is the nibble LSB.
  for (genvar c = 0; c < WORD_W; c++) begin : g_col
    logic [3:0] nib_in;
    logic [3:0] nib_out;
    assign nib_in  = {din[3][c], din[2][c], din[1][c], din[0][c]};
    assign nib_out = box_lookup(box_sel, nib_in);
    for (genvar k = 0; k < LANES; k++) begin : g_bit
      assign dout[k][c] = nib_out[k];
    end
  end

endmodule

// File: rtl/iter_block_cipher_mix.sv
module iter_block_cipher_mix
  import iter_block_cipher_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [LANES-1:0][WORD_W-1:0] din,
  output logic [LANES-1:0][WORD_W-1:0] dout
);

  localparam int ROT_A = 13;
  localparam int ROT_B = 3;
  localparam int ROT_C = 1;
  localparam int ROT_D = 7;
  localparam int ROT_E = 5;
  localparam int ROT_F = 22;
  localparam int SHL_A = 3;
  localparam int SHL_B = 7;

  function automatic logic [WORD_W-1:0] rotl(input logic [WORD_W-1:0] x, input int n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

  always_comb begin
    logic [WORD_W-1:0] m0, m1, m2, m3;
    m0 = rotl(din[0], ROT_A);
    m2 = rotl(din[2], ROT_B);
    m1 = din[1] ^ m0 ^ m2;
    m3 = din[3] ^ m2 ^ (m0 << SHL_A);
    m1 = rotl(m1, ROT_C);
    m3 = rotl(m3, ROT_D);
    m0 = m0 ^ m1 ^ m3;
    m2 = m2 ^ m3 ^ (m1 << SHL_B);
    m0 = rotl(m0, ROT_E);
    m2 = rotl(m2, ROT_F);
    dout[0] = m0;
    dout[1] = m1;
    dout[2] = m2;
    dout[3] = m3;
  end

endmodule

// File: rtl/iter_block_cipher_ctrl.sv
module iter_block_cipher_ctrl #(
  parameter int ROUNDS = 32,
  parameter int IDX_W  = $clog2(ROUNDS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             busy,
  output logic [IDX_W-1:0] rnd,
  output logic             load,
  output logic             last_box,
  output logic             final_xor,
  output logic             done
);

  localparam logic [IDX_W-1:0] LAST_BOX_IDX = IDX_W'(ROUNDS - 1);
  localparam logic [IDX_W-1:0] FINAL_IDX    = IDX_W'(ROUNDS);

  assign load      = start && !busy;
  assign last_box  = busy && (rnd == LAST_BOX_IDX);
  assign final_xor = busy && (rnd == FINAL_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      rnd  <= '0;
      done <= 1'b0;
    end else begin
      done <= final_xor;
      if (load) begin
        busy <= 1'b1;
        rnd  <= '0;
      end else if (busy) begin
        if (final_xor) begin
          busy <= 1'b0;
          rnd  <= '0;
        end else begin
          rnd <= rnd + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/iter_block_cipher.sv
module iter_block_cipher
  import iter_block_cipher_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ROUNDS = 32,
  parameter int IDX_W  = $clog2(ROUNDS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] pt0,
  input  logic [WORD_W-1:0] pt1,
  input  logic [WORD_W-1:0] pt2,
  input  logic [WORD_W-1:0] pt3,
  output logic [IDX_W-1:0]  key_idx,
  input  logic [WORD_W-1:0] sk0,
  input  logic [WORD_W-1:0] sk1,
  input  logic [WORD_W-1:0] sk2,
  input  logic [WORD_W-1:0] sk3,
  output logic [WORD_W-1:0] ct0,
  output logic [WORD_W-1:0] ct1,
  output logic [WORD_W-1:0] ct2,
  output logic [WORD_W-1:0] ct3,
  output logic              done
);

  logic                         ctl_busy;
  logic                         ctl_load;
  logic                         ctl_last_box;
  logic                         ctl_final;
  logic [LANES-1:0][WORD_W-1:0] state_q;
  logic [LANES-1:0][WORD_W-1:0] keyed;
  logic [LANES-1:0][WORD_W-1:0] boxed;
  logic [LANES-1:0][WORD_W-1:0] mixed;
  logic [LANES-1:0][WORD_W-1:0] ct_q;
  logic [LANES-1:0][WORD_W-1:0] subkey;

  iter_block_cipher_ctrl #(
    .ROUNDS(ROUNDS),
    .IDX_W (IDX_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (ctl_busy),
    .rnd      (key_idx),
    .load     (ctl_load),
    .last_box (ctl_last_box),
    .final_xor(ctl_final),
    .done     (done)
  );

  assign subkey = {sk3, sk2, sk1, sk0};
  assign keyed  = state_q ^ subkey;

  iter_block_cipher_sbox #(.WORD_W(WORD_W)) u_sbox (
    .box_sel(key_idx[BOX_SEL_W-1:0]),
    .din    (keyed),
    .dout   (boxed)
  );

  iter_block_cipher_mix #(.WORD_W(WORD_W)) u_mix (
    .din (boxed),
    .dout(mixed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '0;
    end else if (ctl_load) begin
      state_q <= {pt3, pt2, pt1, pt0};
    end else if (ctl_busy && !ctl_final) begin
      state_q <= ctl_last_box ? boxed : mixed;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ct_q <= '0;
    end else if (ctl_final) begin
      ct_q <= keyed;
    end
  end

  assign ct0 = ct_q[0];
  assign ct1 = ct_q[1];
  assign ct2 = ct_q[2];
  assign ct3 = ct_q[3];

endmodule

// File: rtl/iter_block_cipher_chk.sv
module iter_block_cipher_chk #(
  parameter int WORD_W = 32,
  parameter int ROUNDS = 32,
  parameter int IDX_W  = $clog2(ROUNDS + 1)
) (
  input logic                clk,
  input logic                rst,
  input logic                start,
  input logic                busy,
  input logic [IDX_W-1:0]    rnd,
  input logic                done,
  input logic [4*WORD_W-1:0] ct
);

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_after_final_R7: assert property (@(posedge clk) disable iff (rst)
    (armed && done) |-> ($past(busy) && $past(rnd) == IDX_W'(ROUNDS)));

  assert_idle_index_R10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> rnd == '0);

  assert_ct_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (armed && !done) |-> $stable(ct));

  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && rnd != IDX_W'(ROUNDS)) |=> (busy && rnd == IDX_W'($past(rnd) + 1'b1)));

  assert_launch_index_R6: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> (busy && rnd == '0));

endmodule

bind iter_block_cipher iter_block_cipher_chk #(
  .WORD_W(WORD_W),
  .ROUNDS(ROUNDS),
  .IDX_W (IDX_W)
) u_chk (
  .clk  (clk),
  .rst  (rst),
  .start(start),
  .busy (ctl_busy),
  .rnd  (key_idx),
  .done (done),
  .ct   ({ct3, ct2, ct1, ct0})
);

// File: tb/iter_block_cipher_bench.sv
module iter_block_cipher_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NKEYS      = 33;
  localparam int LATENCY    = 33;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] pt0 = '0, pt1 = '0, pt2 = '0, pt3 = '0;
  logic [5:0]  key_idx;
  logic [31:0] sk0, sk1, sk2, sk3;
  logic [31:0] ct0, ct1, ct2, ct3;
  logic        done;

  logic [3:0][31:0] ktab [NKEYS];

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iter_block_cipher u_iter_block_cipher (
    .clk(clk), .rst(rst), .start(start),
    .pt0(pt0), .pt1(pt1), .pt2(pt2), .pt3(pt3),
    .key_idx(key_idx),
    .sk0(sk0), .sk1(sk1), .sk2(sk2), .sk3(sk3),
    .ct0(ct0), .ct1(ct1), .ct2(ct2), .ct3(ct3),
    .done(done)
  );

  // Subkey source answers in the same cycle as the index.
  always_comb begin
    if (key_idx < 6'(NKEYS)) begin
      sk0 = ktab[key_idx][0];
      sk1 = ktab[key_idx][1];
      sk2 = ktab[key_idx][2];
      sk3 = ktab[key_idx][3];
    end else begin
      sk0 = '0; sk1 = '0; sk2 = '0; sk3 = '0;
    end
  end

  // Box tables in listed order: first digit is the output for input 0 (R2).
  function automatic logic [3:0] ref_box(input int b, input logic [3:0] v);
    logic [63:0] t;
    case (b)
      0: t = 64'h38F1A65BED42709C;
      1: t = 64'hFC27905A1BE86D34;
      2: t = 64'h86793CAFD1E40B52;
      3: t = 64'h0FB8C963D124A75E;
      4: t = 64'h1F83C0B6254A9E7D;
      5: t = 64'hF52B4A9C03E8D671;
      6: t = 64'h72C5846BE91FD3A0;
      default: t = 64'h1DF0E82B74CA9356;
    endcase
    return t[63 - 4*int'(v) -: 4];
  endfunction

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    logic [63:0] d;
    d = {x, x} << n;
    return d[63:32];
  endfunction

  function automatic logic [127:0] ref_enc(input logic [3:0][31:0] p);
    logic [3:0][31:0] s;
    logic [3:0][31:0] y;
    logic [31:0] a0, a1, a2, a3;
    s = p;
    for (int r = 0; r < 32; r++) begin
      s = s ^ ktab[r];                                    // R1
      for (int c = 0; c < 32; c++) begin                 // R3
        logic [3:0] o;
        o = ref_box(r % 8, {s[3][c], s[2][c], s[1][c], s[0][c]});
        for (int k = 0; k < 4; k++) y[k][c] = o[k];
      end
      if (r == 31) begin
        s = y ^ ktab[32];                                 // R5
      end else begin                                      // R4
        a0 = rl(y[0], 13); a2 = rl(y[2], 3);
        a1 = y[1] ^ a0 ^ a2; a3 = y[3] ^ a2 ^ {a0[28:0], 3'b000};
        a1 = rl(a1, 1); a3 = rl(a3, 7);
        a0 = a0 ^ a1 ^ a3; a2 = a2 ^ a3 ^ {a1[24:0], 7'b0};
        a0 = rl(a0, 5); a2 = rl(a2, 22);
        s[0] = a0; s[1] = a1; s[2] = a2; s[3] = a3;
      end
    end
    return s;
  endfunction

  function automatic logic [127:0] ct_now();
    return {ct3, ct2, ct1, ct0};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_keys(input int seed);
    for (int i = 0; i < NKEYS; i++)
      for (int j = 0; j < 4; j++)
        ktab[i][j] = (seed == 0) ? 32'h0 :
                     (32'(seed) * 32'h9E3779B9) ^ (32'(i * 4 + j + 1) * 32'h01000193)
                     ^ {16'(seed), 16'(i)};
  endtask

  // Launch at a falling edge; returns at the falling edge after the sampling edge.
  task automatic launch(input logic [3:0][31:0] p);
    @(negedge clk);
    start = 1'b1;
    pt0 = p[0]; pt1 = p[1]; pt2 = p[2]; pt3 = p[3];
    @(negedge clk);
    start = 1'b0;
  endtask

  // Count edges until done; also compares key_idx with the edge count (R6).
  task automatic wait_done(input int mid_start_at, input logic [3:0][31:0] other,
                           output int lat, output bit seq_ok);
    lat = 0;
    seq_ok = 1'b1;
    while (!done && lat < 100) begin
      if (key_idx != 6'(lat)) seq_ok = 1'b0;
      if (lat == mid_start_at) begin
        start = 1'b1;
        pt0 = other[0]; pt1 = other[1]; pt2 = other[2]; pt3 = other[3];
      end
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
  endtask

  task automatic run_one(input logic [3:0][31:0] p, input string tag);
    int lat;
    bit seq_ok;
    logic [127:0] exp;
    exp = ref_enc(p);
    launch(p);
    wait_done(-1, '0, lat, seq_ok);
    chk(lat == LATENCY, "R7", {tag, " done latency"}, 128'(lat), 128'(LATENCY));
    chk(seq_ok, "R6", {tag, " key_idx sequence"}, 128'(seq_ok), 128'(1));
    chk(ct_now() == exp, "R2", {tag, " ciphertext"}, ct_now(), exp);
    @(negedge clk);
    chk(!done, "R7", {tag, " done width"}, 128'(done), 128'(0));
  endtask

  initial begin
    int wd = 0;
    while (wd < 200000) begin
      @(posedge clk);
      wd++;
    end
    fails++;
    checks++;
    $display("FAIL watchdog: actual %0d expected below %0d cycles", wd, 200000);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [3:0][31:0] p;
    logic [3:0][31:0] q;
    logic [127:0] held;
    int lat;
    bit seq_ok;

    set_keys(0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    chk(!done, "R10", "done after reset", 128'(done), 128'(0));
    chk(key_idx == 6'd0, "R10", "key_idx after reset", 128'(key_idx), 128'(0));
    chk(ct_now() == '0, "R10", "ct after reset", ct_now(), '0);

    // R2/R3/R4/R5: uniform column sweep with zero keys
    for (int v = 0; v < 16; v++) begin
      for (int k = 0; k < 4; k++) p[k] = {32{v[k]}};
      run_one(p, "R3 uniform sweep");
    end

    // R1: nonzero keys with walking and mixed plaintexts
    for (int s = 1; s <= 6; s++) begin
      set_keys(s);
      for (int k = 0; k < 4; k++) p[k] = 32'h1 << ((s * 5 + k * 7) % 32);
      run_one(p, "R1 walking bit");
      p[0] = 32'h01234567 * 32'(s); p[1] = 32'h89ABCDEF ^ 32'(s);
      p[2] = 32'hFEDCBA98 + 32'(s); p[3] = ~(32'h76543210 * 32'(s));
      run_one(p, "R1 mixed");
    end

    // R8: hold through idle
    held = ct_now();
    repeat (20) @(negedge clk);
    chk(ct_now() == held, "R8", "ct held while idle", ct_now(), held);

    // R9 and R8: start raised mid-run is ignored; ct held during run
    set_keys(9);
    p[0] = 32'hA5A5F00F; p[1] = 32'h3C3C1234; p[2] = 32'h0BADCAFE; p[3] = 32'h55AA00FF;
    q[0] = 32'hFFFFFFFF; q[1] = 32'h0; q[2] = 32'h12345678; q[3] = 32'h9ABCDEF0;
    launch(p);
    repeat (5) @(negedge clk);
    chk(ct_now() == held, "R8", "ct held during run", ct_now(), held);
    wait_done(5, q, lat, seq_ok);
    chk(lat + 5 == LATENCY, "R9", "done timing with mid-run start", 128'(lat + 5), 128'(LATENCY));
    chk(ct_now() == ref_enc(p), "R9", "result of first block kept", ct_now(), ref_enc(p));
    held = ct_now();
    begin
      bit extra = 1'b0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (done) extra = 1'b1;
      end
      chk(!extra, "R9", "no second done", 128'(extra), 128'(0));
    end
    chk(ct_now() == held, "R8", "ct held after run", ct_now(), held);

    // R10: reset in the middle of a run
    launch(q);
    repeat (7) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(key_idx == 6'd0, "R10", "key_idx after mid-run reset", 128'(key_idx), 128'(0));
    chk(!done, "R10", "done after mid-run reset", 128'(done), 128'(0));
    chk(ct_now() == '0, "R10", "ct after mid-run reset", ct_now(), '0);
    begin
      bit late = 1'b0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (done || key_idx != 6'd0) late = 1'b1;
      end
      chk(!late, "R10", "idle after mid-run reset", 128'(late), 128'(0));
    end

    // Normal operation resumes after reset
    set_keys(11);
    run_one(q, "R6 after reset");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule